// File: doc/BRIEF.md
# Oscillator Frequency Measurement Counter

This block estimates the frequency of a fast oscillator clock by counting its rising edges during a gate window whose length is a power-of-two number of reference clock cycles. Software controls it through level inputs and one-cycle command strobes in the reference domain. It starts a measurement, waits for the busy bit to drop, and reads the captured edge count. From the count and the known window length it derives the ratio between the oscillator and the reference.

The window is timed in the reference domain. The window level is carried into the oscillator domain through a two-flop synchronizer, and the counter there increments while the synchronized level is high. The counter's own view of the window is synchronized back to the reference domain as an acknowledge. The counter value is captured only after that acknowledge has fallen. At that point the multi-bit count has stopped moving, so it can be sampled safely. A manual override lets software hold the window open and hold the counter clear with plain level bits instead of strobes. The oscillator clock is assumed to be faster than the reference clock.

Top module: `lo_freq_meter`

## Requirements
- R1: A `run_cmd` strobe starts a window of exactly 2^(N+1) reference cycles, where N is `gate_code`. The busy bit (`status[COUNT_W]`) is high from the cycle after the strobe until a few cycles after the window ends.
- R2: A `gate_code` above MAX_CODE (12) is treated as MAX_CODE, which gives an 8192-cycle window.
- R3: The captured count equals the number of oscillator rising edges inside the window, within ±3 edges of the clock ratio times the window length.
- R4: The count saturates at 2^COUNT_W-1 and does not wrap.
- R5: `status` carries the busy bit at bit COUNT_W and the count in bits COUNT_W-1:0. The count field reads as zero while `read_en` is 0 and shows the captured count while `read_en` is 1.
- R6: With `ovr_en`=0, a `clear_cmd` strobe zeroes both the counter and the captured count.
- R7: A run does not clear the counter, so successive runs without a clear accumulate.
- R8: With `ovr_en`=1, the window is open for exactly the cycles in which `man_run` is held high, and `man_clear` high holds the counter at zero. In this mode `run_cmd` and `clear_cmd` are ignored.
- R9: While `cnt_enable` is 0, run and clear requests have no effect: busy stays low and the count is kept.
- R10: A run request that arrives while busy is ignored. Neither the window length nor the count changes.
- R11: `done_flag` is set in the cycle busy falls and stays set until a `flag_clr` strobe. `irq` equals `done_flag` AND `irq_en`. After reset, `status`, `done_flag` and `irq` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset (reference domain) |
| lo_clk | input | 1 | Oscillator clock being measured |
| cnt_enable | input | 1 | Global enable for the counter |
| ovr_en | input | 1 | Selects the manual level controls instead of the strobes |
| man_run | input | 1 | Manual window level (override mode) |
| man_clear | input | 1 | Manual clear level (override mode) |
| run_cmd | input | 1 | One-cycle start strobe |
| clear_cmd | input | 1 | One-cycle clear strobe |
| gate_code | input | CODE_W | Window length code N |
| read_en | input | 1 | Shows the count in the status word |
| irq_en | input | 1 | Interrupt enable |
| flag_clr | input | 1 | Write-one strobe that clears the done flag |
| status | output | COUNT_W+1 | {busy, count} |
| done_flag | output | 1 | Sticky measurement-done flag |
| irq | output | 1 | Interrupt request |

## Verification
The checker watches the port relations on every cycle. It checks that the count field is zero whenever `read_en` is low, that the done flag rises exactly when busy falls and holds until cleared, that `irq` never rises without both the flag and its enable, and that a disabled idle block never becomes busy. The bench scenarios cover what depends on the two clocks together. They sweep every window code to check the window lengths and edge counts, and they also cover saturation, accumulation across runs, ignored runs during busy, and manual window control.

// File: rtl/lofm_pkg.sv
package lofm_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_GATE  = 2'd1,
        ST_DRAIN = 2'd2
    } gate_state_e;

    typedef struct packed {
        logic enable;
        logic ovr_en;
        logic man_run;
        logic man_clear;
        logic run_cmd;
        logic clear_cmd;
    } lofm_ctrl_t;

    // Window length in reference cycles for a code, with codes above the limit clamped.
    function automatic int unsigned gate_cycles(input int unsigned code, input int unsigned max_code);
        int unsigned c;
        c = (code > max_code) ? max_code : code;
        return 32'd1 << (c + 1);
    endfunction

endpackage

// File: rtl/lofm_sync.sv
module lofm_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage_q [STAGES];

    always_ff @(posedge clk) begin
        stage_q[0] <= d;
        for (int i = 1; i < STAGES; i++) begin
            stage_q[i] <= stage_q[i-1];
        end
    end

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/lofm_gate.sv
module lofm_gate
    import lofm_pkg::*;
#(
    parameter int CODE_W   = 4,
    parameter int MAX_CODE = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  lofm_ctrl_t        ctrl,
    input  logic [CODE_W-1:0] gate_code,
    input  logic              ack_lvl,
    output logic              gate_lvl,
    output logic              clr_lvl,
    output logic              busy,
    output logic              capture
);
    localparam int TMR_W = MAX_CODE + 1;

    gate_state_e      state_q;
    logic [TMR_W-1:0] tmr_q;
    logic             manual_q;
    logic             seen_q;
    logic             clr_q;
    logic             manual_hold;

    assign manual_hold = ctrl.enable && ctrl.ovr_en && ctrl.man_run;
    assign capture     = (state_q == ST_DRAIN) && seen_q && !ack_lvl;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            tmr_q    <= '0;
            manual_q <= 1'b0;
            seen_q   <= 1'b0;
            clr_q    <= 1'b0;
        end else begin
            clr_q <= ctrl.enable && (ctrl.ovr_en ? ctrl.man_clear : ctrl.clear_cmd);
            unique case (state_q)
                ST_IDLE: begin
                    seen_q <= 1'b0;
                    if (manual_hold) begin
                        state_q  <= ST_GATE;
                        manual_q <= 1'b1;
                    end else if (ctrl.enable && !ctrl.ovr_en && ctrl.run_cmd) begin
                        state_q  <= ST_GATE;
                        manual_q <= 1'b0;
                        tmr_q    <= TMR_W'(gate_cycles(int'(gate_code), MAX_CODE) - 1);
                    end
                end
                ST_GATE: begin
                    if (ack_lvl) seen_q <= 1'b1;
                    if (manual_q) begin
                        if (!manual_hold) state_q <= ST_DRAIN;
                    end else if (tmr_q == '0) begin
                        state_q <= ST_DRAIN;
                    end else begin
                        tmr_q <= tmr_q - 1'b1;
                    end
                end
                ST_DRAIN: begin
                    if (ack_lvl) seen_q <= 1'b1;
                    if (capture) state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign gate_lvl = (state_q == ST_GATE);
    assign clr_lvl  = clr_q;
    assign busy     = (state_q != ST_IDLE);
endmodule

// File: rtl/lofm_lo_counter.sv
module lofm_lo_counter #(
    parameter int COUNT_W = 19
) (
    input  logic               lo_clk,
    input  logic               rst,
    input  logic               gate_lvl,
    input  logic               clr_lvl,
    output logic [COUNT_W-1:0] cnt,
    output logic               gate_seen
);
    localparam logic [COUNT_W-1:0] CNT_MAX = '1;

    logic [2:0]         sync_q;
    logic               lo_rst, gate_s, clr_s;
    logic [COUNT_W-1:0] cnt_q;

    lofm_sync #(.W(3), .STAGES(2)) u_sync (
        .clk (lo_clk),
        .d   ({rst, gate_lvl, clr_lvl}),
        .q   (sync_q)
    );
    assign {lo_rst, gate_s, clr_s} = sync_q;

    always_ff @(posedge lo_clk) begin
        if (lo_rst || clr_s) begin
            cnt_q <= '0;
        end else if (gate_s && cnt_q != CNT_MAX) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign cnt       = cnt_q;
    assign gate_seen = gate_s;
endmodule

// File: rtl/lo_freq_meter.sv
module lo_freq_meter
    import lofm_pkg::*;
#(
    parameter int COUNT_W  = 19,
    parameter int CODE_W   = 4,
    parameter int MAX_CODE = 12
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               lo_clk,
    input  logic               cnt_enable,
    input  logic               ovr_en,
    input  logic               man_run,
    input  logic               man_clear,
    input  logic               run_cmd,
    input  logic               clear_cmd,
    input  logic [CODE_W-1:0]  gate_code,
    input  logic               read_en,
    input  logic               irq_en,
    input  logic               flag_clr,
    output logic [COUNT_W:0]   status,
    output logic               done_flag,
    output logic               irq
);
    lofm_ctrl_t         ctrl;
    logic               gate_lvl, clr_lvl, busy, capture;
    logic               lo_gate_seen, ack_lvl;
    logic [COUNT_W-1:0] lo_cnt;
    logic [COUNT_W-1:0] result_q;
    logic               flag_q;

    assign ctrl = '{enable:    cnt_enable,
                    ovr_en:    ovr_en,
                    man_run:   man_run,
                    man_clear: man_clear,
                    run_cmd:   run_cmd,
                    clear_cmd: clear_cmd};

    lofm_gate #(.CODE_W(CODE_W), .MAX_CODE(MAX_CODE)) u_gate (
        .clk       (clk),
        .rst       (rst),
        .ctrl      (ctrl),
        .gate_code (gate_code),
        .ack_lvl   (ack_lvl),
        .gate_lvl  (gate_lvl),
        .clr_lvl   (clr_lvl),
        .busy      (busy),
        .capture   (capture)
    );

    lofm_lo_counter #(.COUNT_W(COUNT_W)) u_lo (
        .lo_clk    (lo_clk),
        .rst       (rst),
        .gate_lvl  (gate_lvl),
        .clr_lvl   (clr_lvl),
        .cnt       (lo_cnt),
        .gate_seen (lo_gate_seen)
    );

    // Counter's view of the window, returned to the reference domain.
    lofm_sync #(.W(1), .STAGES(2)) u_ack (
        .clk (clk),
        .d   (lo_gate_seen),
        .q   (ack_lvl)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            result_q <= '0;
            flag_q   <= 1'b0;
        end else begin
            if (capture)      result_q <= lo_cnt;
            else if (clr_lvl) result_q <= '0;
            if (capture)       flag_q <= 1'b1;
            else if (flag_clr) flag_q <= 1'b0;
        end
    end

    assign status    = {busy, (read_en ? result_q : '0)};
    assign done_flag = flag_q;
    assign irq       = flag_q && irq_en;
endmodule

// File: rtl/lofm_checker.sv
module lofm_checker #(
    parameter int COUNT_W = 19
) (
    input logic             clk,
    input logic             rst,
    input logic             cnt_enable,
    input logic             read_en,
    input logic             irq_en,
    input logic             flag_clr,
    input logic [COUNT_W:0] status,
    input logic             done_flag,
    input logic             irq
);
    a_r5_hidden_count_zero: assert property (@(posedge clk) disable iff (rst)
        !read_en |-> status[COUNT_W-1:0] == '0);

    a_r11_flag_on_finish: assert property (@(posedge clk) disable iff (rst)
        $fell(status[COUNT_W]) |-> done_flag);

    a_r11_flag_sticky: assert property (@(posedge clk) disable iff (rst)
        (done_flag && !flag_clr && !rst) |=> done_flag);

    a_r11_irq_needs_flag_en: assert property (@(posedge clk) disable iff (rst)
        irq |-> (done_flag && irq_en));

    a_r9_disabled_stays_idle: assert property (@(posedge clk) disable iff (rst)
        (!cnt_enable && !status[COUNT_W]) |=> !status[COUNT_W]);
endmodule

bind lo_freq_meter lofm_checker #(.COUNT_W(COUNT_W)) u_lofm_checker (
    .clk        (clk),
    .rst        (rst),
    .cnt_enable (cnt_enable),
    .read_en    (read_en),
    .irq_en     (irq_en),
    .flag_clr   (flag_clr),
    .status     (status),
    .done_flag  (done_flag),
    .irq        (irq)
);

// File: tb/test_lo_freq_meter.sv
`timescale 1ns/1ps
module test_lo_freq_meter;
    localparam int CW   = 12;
    localparam int MAXC = 12;
    localparam int SAT  = (1 << CW) - 1;

    logic clk = 0, lo_clk = 0, rst = 1;
    logic cnt_enable = 0, ovr_en = 0, man_run = 0, man_clear = 0;
    logic run_cmd = 0, clear_cmd = 0, read_en = 1, irq_en = 0, flag_clr = 0;
    logic [3:0]  gate_code = 0;
    logic [CW:0] status;
    logic        done_flag, irq;

    int checks = 0, fails = 0;

    always #5 clk = ~clk;
    always #2 lo_clk = ~lo_clk;

    lo_freq_meter #(.COUNT_W(CW), .CODE_W(4), .MAX_CODE(MAXC)) i_lo_freq_meter (
        .clk(clk), .rst(rst), .lo_clk(lo_clk), .cnt_enable(cnt_enable), .ovr_en(ovr_en),
        .man_run(man_run), .man_clear(man_clear), .run_cmd(run_cmd), .clear_cmd(clear_cmd),
        .gate_code(gate_code), .read_en(read_en), .irq_en(irq_en), .flag_clr(flag_clr),
        .status(status), .done_flag(done_flag), .irq(irq));

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int cnt_val();
        return int'(status[CW-1:0]);
    endfunction

    // Expected edges: window cycles * 10 ns / 4 ns, with a tolerance of 3 edges.
    function automatic bit near(input int cnt, input int win);
        int d;
        d = 4 * cnt - 10 * win;
        return (d <= 12) && (d >= -12);
    endfunction

    task automatic wait_idle(output int n);
        n = 0;
        while (status[CW]) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic do_clear();
        @(negedge clk); clear_cmd = 1;
        @(negedge clk); clear_cmd = 0;
        repeat (6) @(negedge clk);
    endtask

    task automatic do_run(input int code, output int n);
        @(negedge clk); gate_code = 4'(code); run_cmd = 1;
        @(negedge clk); run_cmd = 0;
        wait_idle(n);
    endtask

    initial begin
        #3_000_000;
        checks++; fails++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        int n, g, c;
        repeat (5) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R11 reset state
        check(status == '0 && !done_flag && !irq, "R11 reset", int'(status), 0);
        cnt_enable = 1;

        // R1 R3 R4 R6 sweep over every window code
        for (int code = 0; code <= MAXC; code++) begin
            do_clear();
            check(cnt_val() == 0, "R6 clear", cnt_val(), 0);
            do_run(code, n);
            g = 1 << (code + 1);
            check(n >= g + 1 && n <= g + 7, "R1 window length", n, g);
            c = cnt_val();
            if (10 * g / 4 + 3 < SAT) check(near(c, g), "R3 edge count", c, 10 * g / 4);
            else                      check(c == SAT, "R4 saturation", c, SAT);
        end

        // R2 codes beyond the limit clamp to the longest window
        do_clear();
        do_run(15, n);
        check(n >= 8193 && n <= 8199, "R2 clamp", n, 8192);

        // R11 done flag, irq gating, write-one clear
        check(done_flag && !irq, "R11 flag set irq off", int'(irq), 0);
        @(negedge clk); irq_en = 1;
        @(negedge clk);
        check(irq == 1, "R11 irq enabled", int'(irq), 1);
        repeat (3) @(negedge clk);
        check(done_flag == 1, "R11 flag sticky", int'(done_flag), 1);
        flag_clr = 1; @(negedge clk); flag_clr = 0; @(negedge clk);
        check(!done_flag && !irq, "R11 flag cleared", int'(done_flag), 0);

        // R7 accumulation across runs, R5 read gating
        do_clear();
        do_run(2, n);
        do_run(2, n);
        c = cnt_val();
        check(near(c, 16), "R7 accumulate", c, 40);
        read_en = 0; @(negedge clk);
        check(status[CW-1:0] == '0 && c != 0, "R5 hidden count", cnt_val(), 0);
        @(negedge clk); gate_code = 4; run_cmd = 1;
        @(negedge clk); run_cmd = 0;
        check(status[CW] == 1 && status[CW-1:0] == '0, "R5 busy above count", int'(status), 1 << CW);
        wait_idle(n);
        read_en = 1; @(negedge clk);

        // R10 run while busy is ignored
        do_clear();
        @(negedge clk); gate_code = 3; run_cmd = 1;
        @(negedge clk); run_cmd = 0;
        repeat (5) @(negedge clk);
        run_cmd = 1; @(negedge clk); run_cmd = 0;
        wait_idle(n);
        check(n >= 6 + 11 - 5 && n <= 16 + 7 - 6, "R10 window unchanged", n + 6, 16);
        check(near(cnt_val(), 16), "R10 count unchanged", cnt_val(), 40);

        // R9 disabled: run and clear have no effect
        c = cnt_val();
        cnt_enable = 0;
        @(negedge clk); run_cmd = 1; clear_cmd = 1;
        @(negedge clk); run_cmd = 0; clear_cmd = 0;
        repeat (8) @(negedge clk);
        check(status[CW] == 0, "R9 no start", int'(status[CW]), 0);
        check(cnt_val() == c, "R9 count kept", cnt_val(), c);
        cnt_enable = 1;

        // R8 manual override: clear level, window level, strobes ignored
        @(negedge clk); ovr_en = 1; man_clear = 1;
        repeat (4) @(negedge clk); man_clear = 0;
        repeat (6) @(negedge clk);
        check(cnt_val() == 0, "R8 manual clear", cnt_val(), 0);
        man_run = 1;
        for (int i = 0; i < 40; i++) begin
            run_cmd = (i == 10);
            @(negedge clk);
        end
        run_cmd = 0; man_run = 0;
        wait_idle(n);
        check(near(cnt_val(), 40), "R8 manual window", cnt_val(), 100);
        c = cnt_val();
        @(negedge clk); clear_cmd = 1;
        @(negedge clk); clear_cmd = 0; run_cmd = 1;
        @(negedge clk); run_cmd = 0;
        repeat (8) @(negedge clk);
        check(cnt_val() == c && status[CW] == 0, "R8 strobes ignored", cnt_val(), c);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule